// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is a 32-bit integer arithmetic and logic unit with a four-bit condition-flag register. It takes two operands, a 4-bit operation code, a set-flags strobe and a carry bit from an outside shifter. In the same cycle it returns a result and a write-enable for the destination register. The arithmetic path is fully combinational. The only state is the flag register, which holds negative, zero, carry and overflow. The stored carry is fed back as the carry-in for the carry-chained operations.

The operations are:
- Plain and carry-chained addition.
- Plain and carry-chained subtraction, each in both operand orders.
- Four bitwise operations: AND, OR, XOR, and AND with the inverted second operand.
- Copy and inverted copy of the second operand.
- Four comparison operations that only update the flags.

Subtraction is done as addition of the inverted operand. The carry flag therefore means "no borrow". Logical operations take their carry from the shifter input and leave the overflow flag as it was.

The unit is driven by an issue stage that presents one operation per cycle. Its interface is plain: there is no handshake, because the result is ready in the same cycle and the flag update always lands on the next edge.

Top module: `int_alu_nzcv`

## Requirements
- R1: While `rst_n` is low, the flag register `nzcv` clears to 4'b0000. The bit order is N at bit 3, Z at bit 2, C at bit 1 and V at bit 0.
- R2: Opcode 0 (add) gives `op_a + op_b`. Opcode 1 (add with carry) gives `op_a + op_b + C`. C becomes the carry out of bit 31. For example, 0xFFFFFFFF + 1 gives 0 with NZCV = 0110.
- R3: For arithmetic opcodes, V is set exactly when the signed result overflows. For example, 0x7FFFFFFF + 1 gives 0x80000000 with NZCV = 1001.
- R4: Opcode 2 (subtract) gives `op_a - op_b`. Opcode 3 (subtract with carry) gives `op_a - op_b - (1 - C)`. C is set to 1 when no borrow occurs.
- R5: Opcode 4 (reverse subtract) gives `op_b - op_a`. Opcode 5 (reverse subtract with carry) gives `op_b - op_a - (1 - C)`. Both use the same not-borrow carry rule as R4.
- R6: The bitwise opcodes are 6 (AND), 7 (OR), 8 (XOR) and 9 (`op_a & ~op_b`). For these, C takes `shift_carry` and V keeps its previous value.
- R7: Opcode 10 copies `op_b` to the result. Opcode 11 gives `~op_b`. Both follow the flag rules of R6.
- R8: The comparison opcodes are 12 (as subtract), 13 (as add), 14 (as AND) and 15 (as XOR). They keep `wr_en` low and update only the flags. Every other opcode drives `wr_en` high.
- R9: When `set_flags` is low, the flag register keeps its value across the clock edge.
- R10: When `set_flags` is high, N takes bit 31 of the result on the next edge, and Z is set exactly when the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| opcode | input | 4 | Operation select, encoded as listed in R2 to R8 |
| set_flags | input | 1 | Load the flag register on this edge |
| shift_carry | input | 1 | Carry supplied by an outside shifter, used by the logical ops |
| result | output | 32 | Combinational result |
| wr_en | output | 1 | High when the result should be written back |
| nzcv | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The bench targets these corner cases:
- **Carry wrap and signed overflow.** The two boundary additions check both. A design that lost bit 32 would report C=0. A design that derived V from the carry alone would flag the wrap case as an overflow.
- **Subtraction carry sense.** Subtractions are run both with and without a borrow. A design with an inverted carry sense fails every flag check on these.
- **Carry-chained variants.** These run after the stored carry has been deliberately forced to both values. A design that ignored the stored carry gives results that are off by one.
- **Logical operations and comparisons.** Logical ops are run with a pending overflow, so a design that cleared V would be caught. Comparisons are checked for a raised write-enable. Vectors with `set_flags` low check that a flag register updating on every edge would drift.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_RSB = 4'd4,
    OP_RSC = 4'd5,
    OP_AND = 4'd6,
    OP_ORR = 4'd7,
    OP_EOR = 4'd8,
    OP_BIC = 4'd9,
    OP_MOV = 4'd10,
    OP_MVN = 4'd11,
    OP_CMP = 4'd12,
    OP_CMN = 4'd13,
    OP_TST = 4'd14,
    OP_TEQ = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         swap,
  input  logic         invert,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  logic [W-1:0] x;
  logic [W-1:0] y;
  logic [W:0]   wide;

  always_comb begin
    x    = swap ? b : a;
    y    = swap ? a : b;
    y    = invert ? ~y : y;
    wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import int_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: res = a & b;
      OP_ORR:         res = a | b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_BIC:         res = a & ~b;
      OP_MOV:         res = b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end

endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg
  import int_alu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  nzcv_t d,
  output nzcv_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (q == 4'b0000));

endmodule

// File: rtl/int_alu_nzcv.sv
module int_alu_nzcv
  import int_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   opcode,
  input  logic         set_flags,
  input  logic         shift_carry,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [3:0]   nzcv
);

  alu_op_e      op;
  nzcv_t        flag_q;
  nzcv_t        flag_d;
  logic         is_arith;
  logic         swap;
  logic         invert;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout;
  logic         ovf;
  logic [W-1:0] logic_res;

  assign op = alu_op_e'(opcode);

  always_comb begin
    is_arith = 1'b0;
    swap     = 1'b0;
    invert   = 1'b0;
    cin      = 1'b0;
    unique case (op)
      OP_ADD, OP_CMN: begin is_arith = 1'b1; end
      OP_ADC:         begin is_arith = 1'b1; cin = flag_q.c; end
      OP_SUB, OP_CMP: begin is_arith = 1'b1; invert = 1'b1; cin = 1'b1; end
      OP_SBC:         begin is_arith = 1'b1; invert = 1'b1; cin = flag_q.c; end
      OP_RSB:         begin is_arith = 1'b1; invert = 1'b1; swap = 1'b1; cin = 1'b1; end
      OP_RSC:         begin is_arith = 1'b1; invert = 1'b1; swap = 1'b1; cin = flag_q.c; end
      default:        ;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(op_b), .swap(swap), .invert(invert), .cin(cin),
    .sum(sum), .cout(cout), .ovf(ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .op(op), .a(op_a), .b(op_b), .res(logic_res)
  );

  always_comb begin
    result   = is_arith ? sum : logic_res;
    wr_en    = !(op inside {OP_CMP, OP_CMN, OP_TST, OP_TEQ});
    flag_d.n = result[W-1];
    flag_d.z = (result == '0);
    flag_d.c = is_arith ? cout : shift_carry;
    flag_d.v = is_arith ? ovf : flag_q.v;
  end

  alu_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .load(set_flags), .d(flag_d), .q(flag_q)
  );

  assign nzcv = flag_q;

  // R8: compare and test encodings never request a write-back
  a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode[3:2] == 2'b11) |-> !wr_en);

  // R6: bitwise ops keep the overflow flag
  a_r6_v_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && !is_arith) |=> (nzcv[0] == $past(nzcv[0])));

  // R10: Z and N follow the result of the previous cycle
  a_r10_nz_track: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> (nzcv[2] == ($past(result) == '0)) && (nzcv[3] == $past(result[W-1])));

  // R6: logical carry comes from the shifter input
  a_r6_c_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && !is_arith) |=> (nzcv[1] == $past(shift_carry)));

endmodule

// File: tb/int_alu_nzcv_bench.sv
module int_alu_nzcv_bench;

  localparam int W = 32;

  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic [3:0]  flags;
    logic        chk_res;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [3:0]  opcode = '0;
  logic        set_flags = 1'b0;
  logic        shift_carry = 1'b0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  nzcv;

  int n_checks = 0;
  int n_fail = 0;
  logic [3:0] mdl_flags = 4'b0000;
  exp_t sb_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  int_alu_nzcv #(.W(W)) u_int_alu_nzcv (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
    .set_flags(set_flags), .shift_carry(shift_carry),
    .result(result), .wr_en(wr_en), .nzcv(nzcv)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference from requirement text
  task automatic apply(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic sf, input logic sc, input string req);
    exp_t e;
    logic [32:0] w;
    logic [31:0] x, y, r;
    logic c_in, c_out, v_out, arith;
    logic cf;
    cf = mdl_flags[1];
    arith = (op <= 5) || op == 12 || op == 13;
    x = a; y = b; c_in = 1'b0;
    case (op)
      0, 13: begin end
      1:     c_in = cf;
      2, 12: begin y = ~b; c_in = 1'b1; end
      3:     begin y = ~b; c_in = cf; end
      4:     begin x = b; y = ~a; c_in = 1'b1; end
      5:     begin x = b; y = ~a; c_in = cf; end
      default: ;
    endcase
    w = {1'b0, x} + {1'b0, y} + {32'd0, c_in};
    c_out = w[32];
    v_out = (x[31] == y[31]) && (w[31] != x[31]);
    case (op)
      6, 14: r = a & b;
      7:     r = a | b;
      8, 15: r = a ^ b;
      9:     r = a & ~b;
      10:    r = b;
      11:    r = ~b;
      default: r = w[31:0];
    endcase
    e.res = r;
    e.wr = (op < 12);
    e.chk_res = (op < 12);
    if (sf)
      mdl_flags = {r[31], r == 32'd0, arith ? c_out : sc, arith ? v_out : mdl_flags[0]};
    e.flags = mdl_flags;
    e.req = req;
    @(negedge clk);
    op_a = a; op_b = b; opcode = op[3:0]; set_flags = sf; shift_carry = sc;
    sb_q.push_back(e);
  endtask

  // monitor: result mid-cycle, flags after the edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.chk_res) check(e.req, "result", result, e.res);
        check(e.req, "wr_en", {31'd0, wr_en}, {31'd0, e.wr});
        @(posedge clk);
        #1;
        check(e.req, "nzcv", {28'd0, nzcv}, {28'd0, e.flags});
      end
    end
  end

  initial begin
    #150000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    check("R1", "reset nzcv", {28'd0, nzcv}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "nzcv after release", {28'd0, nzcv}, 32'd0);

    apply(0, 32'hFFFF_FFFF, 32'h1, 1, 0, "R2");
    apply(0, 32'h7FFF_FFFF, 32'h1, 1, 0, "R3");
    apply(6, 32'hF0F0_F0F0, 32'h0FF0_0000, 1, 1, "R6");   // V pending
    apply(7, 32'h1234_0000, 32'h0000_5678, 1, 0, "R6");
    apply(8, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1, 1, "R6");
    apply(9, 32'hFFFF_FFFF, 32'h0000_FFFF, 1, 0, "R6");
    apply(10, 32'h0, 32'h8000_0001, 1, 1, "R7");
    apply(11, 32'h0, 32'hFFFF_FFFF, 1, 0, "R7");
    apply(2, 32'd5, 32'd3, 1, 0, "R4");
    apply(1, 32'd10, 32'd20, 1, 0, "R2");
    apply(2, 32'd3, 32'd5, 1, 0, "R4");
    apply(3, 32'd100, 32'd1, 1, 0, "R4");
    apply(1, 32'd10, 32'd20, 1, 0, "R2");
    apply(2, 32'h8000_0000, 32'h1, 1, 0, "R3");
    apply(3, 32'd100, 32'd1, 1, 0, "R4");
    apply(4, 32'd3, 32'd10, 1, 0, "R5");
    apply(5, 32'd3, 32'd10, 1, 0, "R5");
    apply(4, 32'd10, 32'd3, 1, 0, "R5");
    apply(5, 32'd3, 32'd10, 1, 0, "R5");
    apply(12, 32'd7, 32'd7, 1, 0, "R8");
    apply(13, 32'hFFFF_FFFF, 32'h1, 1, 0, "R8");
    apply(14, 32'hF0, 32'h0F, 1, 1, "R8");
    apply(15, 32'h8000_0000, 32'h1, 1, 0, "R8");
    apply(0, 32'h7FFF_FFFF, 32'h1, 0, 0, "R9");
    apply(12, 32'd1, 32'd2, 0, 1, "R9");
    apply(11, 32'h0, 32'h0, 0, 1, "R9");
    apply(0, 32'h0, 32'h0, 1, 0, "R10");
    apply(10, 32'h0, 32'h8000_0000, 1, 0, "R10");

    lf = 32'hACE1_2345;
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      b = (i % 7 == 0) ? a : lf;
      apply(i % 16, a, b, (i % 5) != 0, lf[3], "R10");
    end

    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule